// File: doc/BRIEF.md
# Microprogrammed 16-bit Processor Core

A small 16-bit processor with eight general registers. Control comes from a horizontal microprogram held in an internal read-only table. Each instruction is fetched over a word-addressed memory port that uses an address register, a data register, a read strobe, a write strobe and a ready handshake. The core then decodes the instruction and runs the matching microroutine. A microsequencer dispatches on the major opcode and, for the short format, on the extended opcode. Every memory microstep waits in place until the memory reports ready.

A mux on the second ALU operand chooses either the register-B read port or the internal data bus. This allows a 3-bit displacement taken from the instruction word to be added to a base register. The word at the resulting address is then added into a destination register. Trap instructions either present register 0 on a one-cycle output strobe or stop the core. Undefined opcodes also stop it.

Top module: `mpc_core`

## Requirements
- R1: While reset is held, `halted`, `out_valid`, `mem_rd` and `mem_wr` are low. After release, the first memory access is an instruction read at address 0. PC, flags and the microsequencer start from zero.
- R2: `mem_rd` or `mem_wr` stays asserted, with the same `mem_addr` (and `mem_wdata` for writes), until a cycle with `mem_ready` high.
- R3: Instruction word fields. Major op is bits 15:13, the register/condition field is bits 12:10 and the 10-bit address is bits 9:0. In the short format (op 7), the extended op is bits 12:9, a-register bits 8:6, b-register bits 5:3 and displacement bits 2:0. Major ops are 0 load, 1 store, 2 conditional jump, 3 jump-and-link and 7 extended; 4 to 6 are undefined. Extended ops are 0 move, 1 indirect load, 2 indirect store, 3 add, 4 compare, 5 increment, 6 jump-register, 7 displacement add and 8 trap; 9 to 15 are undefined.
- R4: Load copies M[address] into the register named by bits 12:10. Store writes that register to M[address].
- R5: Indirect load copies M[R[a]] into R[b]. Indirect store writes R[a] to M[R[b]]. Addresses use the low 10 bits.
- R6: Move copies R[a] into R[b]. Add sets R[a] = R[a] + R[b]. Increment sets R[a] = R[a] + 1. All arithmetic is modulo 2^16.
- R7: Compare forms R[a] - R[b] and updates only the zero flag Z and the sign flag S (bit 15 of the difference). A conditional jump loads PC from the address field when the condition in bits 12:10 holds: 0 always, 1 Z, 2 not Z, 3 S, 4 S or Z, 5 not S or not Z, 6 not S. Code 7 never holds. When the condition fails, execution continues at the next instruction.
- R8: Jump-and-link writes the incremented PC into the register named by bits 12:10, then jumps to the address field. Jump-register loads PC from R[a].
- R9: Displacement add sets R[a] = R[a] + M[(disp + R[b]) mod 1024], with disp the unsigned 3-bit field.
- R10: A trap with a-field 1 raises `out_valid` for exactly one cycle, with `out_data` equal to R0. A trap with an a-field other than 0 or 1 does nothing.
- R11: A trap with a-field 0, or any undefined major or extended op, sets `halted`. `halted` stays set, and no further memory strobe or output strobe occurs until reset.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Word address of the current access |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_ready | input | 1 | Memory has completed the access this cycle |
| mem_rdata | input | 16 | Read data, valid when `mem_ready` is high |
| out_valid | output | 1 | One-cycle strobe from a print trap |
| out_data | output | 16 | Value of R0 captured by the print trap |
| halted | output | 1 | Core has stopped |

## Verification
A memory write is due on the cycle its strobe meets `mem_ready`. The bench checks its address and data against the next expected event on the falling edge where it grants ready. A print trap raises `out_valid` one edge after its microstep, and `halted` follows its stopping microstep by one edge. The bench therefore samples both on every falling edge and matches them in order against a queue produced by an instruction-level model of the same program. Memory latency rotates through 0, 1 and 2 wait cycles, so the ready handshake is exercised with both immediate and delayed completion.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int UPC_W = 6;

    typedef enum logic [2:0] {D_NONE, D_MAR, D_MDR, D_IR, D_REG, D_PC} dest_e;
    typedef enum logic [2:0] {S_NONE, S_PC, S_ADS, S_MDR, S_REG, S_T, S_DISP} src_e;
    typedef enum logic [1:0] {RS_F0, RS_F1, RS_F2, RS_ZERO} rsel_e;
    typedef enum logic [2:0] {ALU_NONE, ALU_PASS, ALU_ADD, ALU_SUB, ALU_INC} alu_e;
    typedef enum logic [1:0] {M_NONE, M_RD, M_WR} mem_e;
    typedef enum logic [2:0] {Q_NEXT, Q_JUMP, Q_WAIT, Q_DECODE, Q_TESTCC, Q_TRAP, Q_STOP} seq_e;

    typedef struct packed {
        dest_e             dest;
        src_e              src;
        rsel_e             rsel;
        logic              asel_b;
        logic              bmux_bus;
        alu_e              alu;
        mem_e              mem;
        logic              pcinc;
        seq_e              seq;
        logic [UPC_W-1:0]  target;
    } uop_t;

    localparam logic [UPC_W-1:0] U_FETCH = 6'd0;
    localparam logic [UPC_W-1:0] U_LD    = 6'd3;
    localparam logic [UPC_W-1:0] U_ST    = 6'd6;
    localparam logic [UPC_W-1:0] U_LDR   = 6'd9;
    localparam logic [UPC_W-1:0] U_STR   = 6'd12;
    localparam logic [UPC_W-1:0] U_MOV   = 6'd15;
    localparam logic [UPC_W-1:0] U_ADD   = 6'd17;
    localparam logic [UPC_W-1:0] U_CMP   = 6'd19;
    localparam logic [UPC_W-1:0] U_INC   = 6'd20;
    localparam logic [UPC_W-1:0] U_JMP   = 6'd22;
    localparam logic [UPC_W-1:0] U_JAL   = 6'd24;
    localparam logic [UPC_W-1:0] U_JR    = 6'd26;
    localparam logic [UPC_W-1:0] U_ADDD  = 6'd27;
    localparam logic [UPC_W-1:0] U_TRAP  = 6'd32;
    localparam logic [UPC_W-1:0] U_BAD   = 6'd33;
endpackage

// File: rtl/mpc_ucode_rom.sv
module mpc_ucode_rom
    import mpc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [UPC_W-1:0] upc,
    input  logic [DW-1:0]    dec_word,
    output uop_t             uop,
    output logic [UPC_W-1:0] dispatch
);
    // control store: one horizontal word per micro-address
    always_comb begin
        uop = '0;
        case (upc)
            U_FETCH:     begin uop.dest = D_MAR; uop.src = S_PC; end
            U_FETCH+1:   begin uop.mem = M_RD; uop.seq = Q_WAIT; uop.target = U_FETCH + 6'd2; end
            U_FETCH+2:   begin uop.dest = D_IR; uop.src = S_MDR; uop.pcinc = 1'b1; uop.seq = Q_DECODE; end
            U_LD:        begin uop.dest = D_MAR; uop.src = S_ADS; end
            U_LD+1:      begin uop.mem = M_RD; uop.seq = Q_WAIT; uop.target = U_LD + 6'd2; end
            U_LD+2:      begin uop.dest = D_REG; uop.src = S_MDR; uop.rsel = RS_F0; uop.seq = Q_JUMP; end
            U_ST:        begin uop.dest = D_MAR; uop.src = S_ADS; end
            U_ST+1:      begin uop.dest = D_MDR; uop.src = S_REG; uop.rsel = RS_F0; end
            U_ST+2:      begin uop.mem = M_WR; uop.seq = Q_WAIT; end
            U_LDR:       begin uop.dest = D_MAR; uop.src = S_REG; uop.rsel = RS_F1; end
            U_LDR+1:     begin uop.mem = M_RD; uop.seq = Q_WAIT; uop.target = U_LDR + 6'd2; end
            U_LDR+2:     begin uop.dest = D_REG; uop.src = S_MDR; uop.rsel = RS_F2; uop.seq = Q_JUMP; end
            U_STR:       begin uop.dest = D_MAR; uop.src = S_REG; uop.rsel = RS_F2; end
            U_STR+1:     begin uop.dest = D_MDR; uop.src = S_REG; uop.rsel = RS_F1; end
            U_STR+2:     begin uop.mem = M_WR; uop.seq = Q_WAIT; end
            U_MOV:       begin uop.alu = ALU_PASS; end
            U_MOV+1:     begin uop.dest = D_REG; uop.src = S_T; uop.rsel = RS_F2; uop.seq = Q_JUMP; end
            U_ADD:       begin uop.alu = ALU_ADD; end
            U_ADD+1:     begin uop.dest = D_REG; uop.src = S_T; uop.rsel = RS_F1; uop.seq = Q_JUMP; end
            U_CMP:       begin uop.alu = ALU_SUB; uop.seq = Q_JUMP; end
            U_INC:       begin uop.alu = ALU_INC; end
            U_INC+1:     begin uop.dest = D_REG; uop.src = S_T; uop.rsel = RS_F1; uop.seq = Q_JUMP; end
            U_JMP:       begin uop.seq = Q_TESTCC; end
            U_JMP+1:     begin uop.dest = D_PC; uop.src = S_ADS; uop.seq = Q_JUMP; end
            U_JAL:       begin uop.dest = D_REG; uop.src = S_PC; uop.rsel = RS_F0; end
            U_JAL+1:     begin uop.dest = D_PC; uop.src = S_ADS; uop.seq = Q_JUMP; end
            U_JR:        begin uop.dest = D_PC; uop.src = S_REG; uop.rsel = RS_F1; uop.seq = Q_JUMP; end
            U_ADDD:      begin uop.src = S_DISP; uop.asel_b = 1'b1; uop.bmux_bus = 1'b1; uop.alu = ALU_ADD; end
            U_ADDD+1:    begin uop.dest = D_MAR; uop.src = S_T; end
            U_ADDD+2:    begin uop.mem = M_RD; uop.seq = Q_WAIT; uop.target = U_ADDD + 6'd3; end
            U_ADDD+3:    begin uop.src = S_MDR; uop.bmux_bus = 1'b1; uop.alu = ALU_ADD; end
            U_ADDD+4:    begin uop.dest = D_REG; uop.src = S_T; uop.rsel = RS_F1; uop.seq = Q_JUMP; end
            U_TRAP:      begin uop.src = S_REG; uop.rsel = RS_ZERO; uop.seq = Q_TRAP; end
            default:     begin uop.seq = Q_STOP; end
        endcase
    end

    // two-level dispatch: major op, then extended op for op 7
    always_comb begin
        dispatch = U_BAD;
        case (dec_word[15:13])
            3'd0: dispatch = U_LD;
            3'd1: dispatch = U_ST;
            3'd2: dispatch = U_JMP;
            3'd3: dispatch = U_JAL;
            3'd7: begin
                case (dec_word[12:9])
                    4'd0:    dispatch = U_MOV;
                    4'd1:    dispatch = U_LDR;
                    4'd2:    dispatch = U_STR;
                    4'd3:    dispatch = U_ADD;
                    4'd4:    dispatch = U_CMP;
                    4'd5:    dispatch = U_INC;
                    4'd6:    dispatch = U_JR;
                    4'd7:    dispatch = U_ADDD;
                    4'd8:    dispatch = U_TRAP;
                    default: dispatch = U_BAD;
                endcase
            end
            default: dispatch = U_BAD;
        endcase
    end
endmodule

// File: rtl/mpc_alu.sv
module mpc_alu
    import mpc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_e          op,
    output logic [DW-1:0] res,
    output logic          zf,
    output logic          sf
);
    always_comb begin
        case (op)
            ALU_PASS: res = a;
            ALU_ADD:  res = a + b;
            ALU_SUB:  res = a - b;
            ALU_INC:  res = a + {{(DW-1){1'b0}}, 1'b1};
            default:  res = a;
        endcase
        zf = (res == '0);
        sf = res[DW-1];
    end
endmodule

// File: rtl/mpc_regfile.sv
module mpc_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] ra_bus,
    output logic [DW-1:0] rd_bus,
    input  logic [RW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [RW-1:0] ra_b,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (we) regs_q[waddr] <= wdata;
    end

    assign rd_bus = regs_q[ra_bus];
    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
endmodule

// File: rtl/mpc_core.sv
module mpc_core
    import mpc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 10,
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          halted
);
    localparam int RW    = $clog2(NREG);
    localparam int IRW   = 13;   // op bits are only needed at dispatch time
    localparam int ADS_W = 10;
    localparam int DSP_W = 3;

    typedef struct packed {
        logic [UPC_W-1:0] upc;
        logic [DW-1:0]    pc;
        logic [IRW-1:0]   ir;
        logic [AW-1:0]    mar;
        logic [DW-1:0]    mdr;
        logic [DW-1:0]    t;
        logic             z;
        logic             s;
        logic             halted;
        logic             ov;
        logic [DW-1:0]    od;
    } st_t;

    st_t q, d;

    uop_t             u;
    logic [UPC_W-1:0] disp_upc;
    logic [DW-1:0]    bus, rf_bus, rf_a, rf_b, alu_b, alu_res;
    logic             alu_z, alu_s, wen, cc_ok;
    logic [RW-1:0]    rsel_idx, a_idx;
    logic [2:0]       ccode, trap_code;

    mpc_ucode_rom #(.DW(DW)) u_rom (
        .upc      (q.upc),
        .dec_word (q.mdr),
        .uop      (u),
        .dispatch (disp_upc)
    );

    always_comb begin
        case (u.rsel)
            RS_F0:   rsel_idx = q.ir[12:10];
            RS_F1:   rsel_idx = q.ir[8:6];
            RS_F2:   rsel_idx = q.ir[5:3];
            default: rsel_idx = '0;
        endcase
        a_idx = u.asel_b ? q.ir[5:3] : q.ir[8:6];
    end

    mpc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk    (clk),
        .we     (wen),
        .waddr  (rsel_idx),
        .wdata  (bus),
        .ra_bus (rsel_idx),
        .rd_bus (rf_bus),
        .ra_a   (a_idx),
        .rd_a   (rf_a),
        .ra_b   (q.ir[5:3]),
        .rd_b   (rf_b)
    );

    always_comb begin
        case (u.src)
            S_PC:    bus = q.pc;
            S_ADS:   bus = {{(DW-ADS_W){1'b0}}, q.ir[ADS_W-1:0]};
            S_MDR:   bus = q.mdr;
            S_REG:   bus = rf_bus;
            S_T:     bus = q.t;
            S_DISP:  bus = {{(DW-DSP_W){1'b0}}, q.ir[DSP_W-1:0]};
            default: bus = '0;
        endcase
    end

    // second ALU operand: register-B port or the internal bus
    assign alu_b = u.bmux_bus ? bus : rf_b;

    mpc_alu #(.DW(DW)) u_alu (
        .a   (rf_a),
        .b   (alu_b),
        .op  (u.alu),
        .res (alu_res),
        .zf  (alu_z),
        .sf  (alu_s)
    );

    assign ccode     = q.ir[12:10];
    assign trap_code = q.ir[8:6];

    always_comb begin
        case (ccode)
            3'd0:    cc_ok = 1'b1;
            3'd1:    cc_ok = q.z;
            3'd2:    cc_ok = !q.z;
            3'd3:    cc_ok = q.s;
            3'd4:    cc_ok = q.s || q.z;
            3'd5:    cc_ok = !q.s || !q.z;
            3'd6:    cc_ok = !q.s;
            default: cc_ok = 1'b0;
        endcase
    end

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        wen  = 1'b0;
        if (!q.halted) begin
            case (u.dest)
                D_MAR:   d.mar = bus[AW-1:0];
                D_MDR:   d.mdr = bus;
                D_IR:    d.ir  = bus[IRW-1:0];
                D_PC:    d.pc  = bus;
                D_REG:   wen   = 1'b1;
                default: ;
            endcase
            if (u.mem == M_RD && mem_ready) d.mdr = mem_rdata;
            if (u.pcinc) d.pc = q.pc + {{(DW-1){1'b0}}, 1'b1};
            if (u.alu != ALU_NONE) d.t = alu_res;
            if (u.alu == ALU_SUB) begin
                d.z = alu_z;
                d.s = alu_s;
            end
            case (u.seq)
                Q_NEXT:   d.upc = q.upc + 1'b1;
                Q_JUMP:   d.upc = u.target;
                Q_WAIT:   if (mem_ready) d.upc = u.target;
                Q_DECODE: d.upc = disp_upc;
                Q_TESTCC: d.upc = cc_ok ? q.upc + 1'b1 : U_FETCH;
                Q_TRAP: begin
                    if (trap_code == 3'd1) begin
                        d.ov  = 1'b1;
                        d.od  = bus;
                        d.upc = U_FETCH;
                    end else if (trap_code == 3'd0) begin
                        d.halted = 1'b1;
                    end else begin
                        d.upc = U_FETCH;
                    end
                end
                default:  d.halted = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = q.mar;
    assign mem_wdata = q.mdr;
    assign mem_rd    = (u.mem == M_RD) && !q.halted;
    assign mem_wr    = (u.mem == M_WR) && !q.halted;
    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign halted    = q.halted;

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!mem_rd && !mem_wr && !out_valid));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/sim_mpc_core.sv
module sim_mpc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0, out_data;
    logic        mem_rd, mem_wr, mem_ready = 1'b0, out_valid, halted;

    always #4 clk = ~clk;

    mpc_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .halted(halted)
    );

    int n_chk = 0, n_bad = 0;
    logic [15:0] mem [1024];
    logic [15:0] img [1024];
    int          ex_kind [$];
    logic [15:0] ex_addr [$];
    logic [15:0] ex_data [$];
    string       ex_tag  [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic take_event(input int kind, input logic [15:0] a, input logic [15:0] v);
        logic [31:0] act;
        act = {5'd0, kind[0], a[9:0], v};
        if (ex_kind.size() == 0) begin
            check(1'b0, "R3 unexpected event", act, 32'h0);
        end else begin
            int          k = ex_kind.pop_front();
            logic [15:0] ea = ex_addr.pop_front();
            logic [15:0] ev = ex_data.pop_front();
            string       t = ex_tag.pop_front();
            logic [31:0] exp = {5'd0, k[0], ea[9:0], ev};
            check(act == exp, t, act, exp);
        end
    endtask

    // memory model with rotating latency, plus event capture
    int   lat = 0, cnt = 0, nacc = 0;
    logic [9:0] a0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_rd || mem_wr) begin
            if (cnt == 0) a0 = mem_addr;
            if (cnt >= lat) begin
                check(mem_addr == a0, "R2 address held", {22'd0, mem_addr}, {22'd0, a0});
                check(!(mem_rd && mem_wr), "R12 strobes exclusive", {31'd0, mem_wr}, 32'd0);
                mem_ready = 1'b1;
                nacc++;
                lat = nacc % 3;
                if (mem_rd) mem_rdata = mem[mem_addr];
                else begin
                    mem[mem_addr] = mem_wdata;
                    take_event(0, {6'd0, mem_addr}, mem_wdata);
                end
            end else cnt++;
        end
        if (rst_n && out_valid) take_event(1, 16'd0, out_data);
    end

    function automatic logic [15:0] fl(int op, int r, int ads);
        return {op[2:0], r[2:0], ads[9:0]};
    endfunction
    function automatic logic [15:0] fs(int x, int a, int b, int dsp);
        return {3'd7, x[3:0], a[2:0], b[2:0], dsp[2:0]};
    endfunction

    function automatic bit cond_holds(logic [2:0] c, bit z, bit s);
        if (c == 0) return 1;
        if (c == 1) return z;
        if (c == 2) return !z;
        if (c == 3) return s;
        if (c == 4) return s | z;
        if (c == 5) return !s | !z;
        if (c == 6) return !s;
        return 0;
    endfunction

    // instruction-level reference model
    task automatic model_run();
        logic [15:0] m [1024];
        logic [15:0] r [8];
        string       rt [8];
        string       ct = "";
        logic [15:0] pc = 0, ir, dif;
        bit          z = 0, s = 0;
        for (int i = 0; i < 1024; i++) m[i] = img[i];
        for (int i = 0; i < 8; i++) begin r[i] = 0; rt[i] = ""; end
        for (int step = 0; step < 2000; step++) begin
            logic [2:0] op, f0, ra, rb, dsp;
            logic [3:0] xo;
            logic [9:0] ads;
            ir = m[pc[9:0]];
            pc = pc + 1;
            op = ir[15:13]; f0 = ir[12:10]; ads = ir[9:0];
            xo = ir[12:9]; ra = ir[8:6]; rb = ir[5:3]; dsp = ir[2:0];
            if (op == 0) begin r[f0] = m[ads]; rt[f0] = "R4"; end
            else if (op == 1) begin
                m[ads] = r[f0];
                ex_kind.push_back(0); ex_addr.push_back({6'd0, ads}); ex_data.push_back(r[f0]);
                ex_tag.push_back({"R4 store ", rt[f0], " ", ct});
            end
            else if (op == 2) begin
                if (cond_holds(f0, z, s)) pc = {6'd0, ads};
                ct = "R7";
            end
            else if (op == 3) begin r[f0] = pc; rt[f0] = "R8"; pc = {6'd0, ads}; ct = "R8"; end
            else if (op == 7) begin
                case (xo)
                    0: begin r[rb] = r[ra]; rt[rb] = "R6"; end
                    1: begin r[rb] = m[r[ra][9:0]]; rt[rb] = "R5"; end
                    2: begin
                        m[r[rb][9:0]] = r[ra];
                        ex_kind.push_back(0); ex_addr.push_back({6'd0, r[rb][9:0]}); ex_data.push_back(r[ra]);
                        ex_tag.push_back({"R5 store ", rt[ra], " ", ct});
                    end
                    3: begin r[ra] = r[ra] + r[rb]; rt[ra] = "R6"; end
                    4: begin dif = r[ra] - r[rb]; z = (dif == 0); s = dif[15]; ct = "R7"; end
                    5: begin r[ra] = r[ra] + 1; rt[ra] = "R6"; end
                    6: begin pc = r[ra]; ct = "R8"; end
                    7: begin
                        r[ra] = r[ra] + m[(r[rb] + {13'd0, dsp}) & 16'h3FF]; rt[ra] = "R9";
                    end
                    8: begin
                        if (ra == 1) begin
                            ex_kind.push_back(1); ex_addr.push_back(0); ex_data.push_back(r[0]);
                            ex_tag.push_back({"R10 print ", rt[0], " ", ct});
                        end else if (ra == 0) return;
                    end
                    default: return;
                endcase
            end
            else return;
        end
    endtask

    task automatic run_prog(input string name);
        int cyc = 0;
        bit wd = 0;
        for (int i = 0; i < 1024; i++) mem[i] = img[i];
        ex_kind.delete(); ex_addr.delete(); ex_data.delete(); ex_tag.delete();
        model_run();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!halted && !out_valid, "R1 reset outputs", {30'd0, halted, out_valid}, 32'd0);
        check(!mem_rd && !mem_wr, "R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        while (!mem_rd) @(negedge clk);
        check(mem_addr == 0, "R1 first fetch address", {22'd0, mem_addr}, 32'd0);
        while (!halted && !wd) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) wd = 1;
        end
        check(!wd, {"R11 watchdog ", name}, cyc, 20000);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || out_valid || !halted)
                check(1'b0, "R11 quiet after halt", {29'd0, halted, mem_rd, mem_wr}, 32'h4);
        end
        check(halted, "R11 halt sticky", {31'd0, halted}, 32'd1);
        check(ex_kind.size() == 0, {"R3 R11 all events seen ", name}, ex_kind.size(), 0);
    endtask

    initial begin
        // program A: every instruction class
        for (int i = 0; i < 1024; i++) img[i] = 16'h0;
        img[0]  = fl(0, 0, 100);
        img[1]  = fl(0, 2, 101);
        img[2]  = fs(7, 0, 2, 2);
        img[3]  = fs(8, 1, 0, 0);
        img[4]  = fl(1, 0, 200);
        img[5]  = fl(0, 1, 102);
        img[6]  = fs(3, 0, 1, 0);
        img[7]  = fs(5, 1, 0, 0);
        img[8]  = fs(0, 1, 3, 0);
        img[9]  = fs(2, 3, 2, 0);
        img[10] = fs(1, 2, 4, 0);
        img[11] = fs(4, 4, 3, 0);
        img[12] = fl(2, 2, 40);
        img[13] = fl(2, 1, 15);
        img[14] = fs(8, 0, 0, 0);
        img[15] = fl(1, 4, 201);
        img[16] = fs(7, 4, 2, 7);
        img[17] = fl(1, 4, 202);
        img[18] = fl(3, 5, 50);
        img[19] = fs(8, 1, 0, 0);
        img[20] = fs(4, 1, 0, 0);
        img[21] = fl(2, 3, 23);
        img[22] = fs(8, 0, 0, 0);
        img[23] = fl(2, 6, 40);
        img[24] = fl(2, 5, 26);
        img[25] = fs(8, 0, 0, 0);
        img[26] = fs(5, 0, 0, 0);
        img[27] = fs(8, 1, 0, 0);
        img[28] = fs(8, 2, 0, 0);
        img[29] = fs(8, 0, 0, 0);
        img[40] = fs(8, 0, 0, 0);
        img[50] = fs(3, 0, 0, 0);
        img[51] = fl(1, 0, 203);
        img[52] = fs(6, 5, 0, 0);
        img[100] = 16'd1;
        img[101] = 16'd110;
        img[102] = 16'd5;
        img[112] = 16'd8;
        img[117] = 16'h0123;
        run_prog("A");

        // program B: undefined extended op stops the core
        for (int i = 0; i < 1024; i++) img[i] = 16'h0;
        img[0] = fl(0, 0, 100);
        img[1] = fl(1, 0, 150);
        img[2] = fs(12, 0, 0, 0);
        img[3] = fl(1, 0, 151);
        img[100] = 16'hBEEF;
        run_prog("B");

        // program C: undefined major op stops the core
        for (int i = 0; i < 1024; i++) img[i] = 16'h0;
        img[0] = fl(0, 0, 100);
        img[1] = fs(8, 1, 0, 0);
        img[2] = fl(5, 0, 0);
        img[3] = fs(8, 1, 0, 0);
        img[100] = 16'h8001;
        run_prog("C");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule